// File: doc/BRIEF.md
# Four-Pin Bridge PWM Generator

This block produces a pulse-width-modulated waveform with ten bits of duty resolution and routes it onto four output pins, named A to D, so that one block can drive a single switched load, a complementary half-bridge pair, or an H-bridge in either direction. An external free-running counter supplies the period timebase as a 10-bit count together with a one-cycle wrap pulse that marks count zero. The duty value is assembled from an 8-bit high part and a 2-bit low part. It is captured into a shadow register at each wrap, so software may rewrite it at any time without producing a runt pulse.

A 4-bit mode input enables the generator and picks the active level of pins A/C and of pins B/D separately. A 2-bit configuration input selects the steering pattern. In the half-bridge pattern, each of the two complementary outputs waits a programmable number of clock cycles before it turns active, so the pair is never active together. For every pin, an enable output tells the surrounding I/O whether the generator owns that pin. A released pin has its enable low and its level output at 0.

Top module: `epwm_steer`

## Requirements
- R1: The duty value is D = duty_hi*4 + duty_lo (10 bits). The modulated signal is active exactly in the cycles whose timebase count c satisfies c < D. It appears at the pins two clock cycles after the count that produced it.
- R2: With D = 0 the modulated signal is never active. With D greater than the largest count of the period it is active for the whole period.
- R3: The duty value is taken only in the cycle where tb_wrap is 1. A duty change made in the middle of a period has no effect until the next wrap.
- R4: Configuration 2'b00 (single): only pin A (bit 0) is enabled and carries the modulated signal. Pins B, C and D (bits 1 to 3) are released.
- R5: Configuration 2'b01 (forward bridge): all four pins are enabled. D carries the modulated signal, A is held active, and B and C are held inactive.
- R6: Configuration 2'b10 (half-bridge): A carries the modulated signal and B carries its complement. Only A and B are enabled. Each of them turns active only after its own input has been active for dead_dly+1 consecutive cycles, and it turns inactive without delay.
- R7: Configuration 2'b11 (reverse bridge): all four pins are enabled. B carries the modulated signal, C is held active, and A and D are held inactive.
- R8: In PWM modes (mode[3:2] = 2'b11), mode[1] = 1 makes pins A and C active-low and mode[0] = 1 makes pins B and D active-low. A 0 in either bit means active-high, and an inactive pin sits at the opposite level.
- R9: When mode[3:2] is not 2'b11, every pin is released: pin_en = 4'b0000 and pin_lvl = 4'b0000.
- R10: Mode 4'b0000 clears the duty shadow and the dead-band state. After re-enabling in mid-period, the output stays inactive until the next wrap.
- R11: In the half-bridge configuration, the active states of A and B never overlap in any cycle.
- R12: While rst is high, the modulated signals are inactive, so enabled pins sit at their inactive level. For example, mode 4'b1110 with configuration 2'b00 gives pin_en = 4'b0001 and pin_lvl = 4'b0001.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tb_count | input | 10 | Period timebase count |
| tb_wrap | input | 1 | One-cycle pulse in the cycle where the timebase count is zero |
| duty_hi | input | 8 | Upper eight bits of the duty value |
| duty_lo | input | 2 | Lower two bits of the duty value |
| out_cfg | input | 2 | Steering pattern: single, forward, half-bridge, reverse |
| mode | input | 4 | Enable and per-pair polarity; 0000 clears the state |
| dead_dly | input | 6 | Half-bridge turn-on delay in clock cycles |
| pin_lvl | output | 4 | Pin levels, bit 0 = A to bit 3 = D |
| pin_en | output | 4 | Pin ownership: 1 = driven by this block |

## Verification
Two events can land in the same cycle. A duty rewrite can coincide with a wrap, or fall just before one. A mode clear can arrive while the modulated output is active, and the generator can then be re-enabled in mid-period. The bench rewrites the duty halfway through a period, and it drops the mode to 0000 during an active phase. Its cycle model captures duty only on wrap and treats a clear as zeroing the shadow. Each sampled pin is compared with that model, so a capture at the wrong moment shows up as a pulse of the wrong length.

// File: rtl/epwm_steer_pkg.sv
package epwm_steer_pkg;

    localparam int CNT_W_DEF   = 10;
    localparam int HI_W_DEF    = 8;
    localparam int DEAD_W_DEF  = 6;
    localparam int NPIN        = 4;

    typedef enum logic [1:0] {
        CFG_SINGLE = 2'b00,
        CFG_FWD    = 2'b01,
        CFG_HALF   = 2'b10,
        CFG_REV    = 2'b11
    } steer_cfg_e;

    typedef struct packed {
        logic [NPIN-1:0] act;
        logic [NPIN-1:0] en;
    } pin_drive_t;

    function automatic logic mode_is_pwm(input logic [3:0] m);
        return m[3:2] == 2'b11;
    endfunction

    function automatic logic mode_is_off(input logic [3:0] m);
        return m == 4'b0000;
    endfunction

    // Polarity mask per pin: bit 0 = A, 1 = B, 2 = C, 3 = D.
    function automatic logic [NPIN-1:0] pol_mask(input logic [3:0] m);
        return {m[0], m[1], m[0], m[1]};
    endfunction

endpackage

// File: rtl/epwm_duty_cmp.sv
module epwm_duty_cmp
    import epwm_steer_pkg::*;
#(
    parameter int CNT_W = CNT_W_DEF,
    parameter int HI_W  = HI_W_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             wrap,
    input  logic [CNT_W-1:0] cnt,
    input  logic [HI_W-1:0]  duty_hi,
    input  logic [CNT_W-HI_W-1:0] duty_lo,
    output logic             pwm_o,
    output logic [CNT_W-1:0] shadow_o
);
    logic [CNT_W-1:0] duty_new;
    assign duty_new = {duty_hi, duty_lo};

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            shadow_o <= '0;
            pwm_o    <= 1'b0;
        end else if (wrap) begin
            shadow_o <= duty_new;
            pwm_o    <= (duty_new != '0);
        end else if (cnt == shadow_o) begin
            pwm_o    <= 1'b0;
        end
    end
endmodule

// File: rtl/epwm_deadband.sv
module epwm_deadband
    import epwm_steer_pkg::*;
#(
    parameter int DEAD_W = DEAD_W_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              in_i,
    input  logic [DEAD_W-1:0] dly_i,
    output logic              out_o
);
    logic [DEAD_W-1:0] wait_q;

    always_ff @(posedge clk) begin
        if (rst || clr || !in_i) begin
            out_o  <= 1'b0;
            wait_q <= '0;
        end else if (!out_o) begin
            if (wait_q == dly_i) out_o <= 1'b1;
            else                 wait_q <= wait_q + 1'b1;
        end
    end
endmodule

// File: rtl/epwm_route.sv
module epwm_route
    import epwm_steer_pkg::*;
(
    input  logic [3:0]      mode,
    input  logic [1:0]      out_cfg,
    input  logic            mod_a,
    input  logic            mod_b,
    output logic [NPIN-1:0] pin_lvl,
    output logic [NPIN-1:0] pin_en
);
    pin_drive_t drv;

    always_comb begin
        drv = '0;
        case (steer_cfg_e'(out_cfg))
            CFG_SINGLE: begin
                drv.act = {3'b000, mod_a};
                drv.en  = 4'b0001;
            end
            CFG_FWD: begin
                drv.act = {mod_a, 1'b0, 1'b0, 1'b1};
                drv.en  = 4'b1111;
            end
            CFG_HALF: begin
                drv.act = {2'b00, mod_b, mod_a};
                drv.en  = 4'b0011;
            end
            default: begin
                drv.act = {1'b0, 1'b1, mod_a, 1'b0};
                drv.en  = 4'b1111;
            end
        endcase
        if (!mode_is_pwm(mode)) drv = '0;
    end

    assign pin_en  = drv.en;
    assign pin_lvl = drv.en & (drv.act ^ pol_mask(mode));
endmodule

// File: rtl/epwm_steer.sv
module epwm_steer
    import epwm_steer_pkg::*;
#(
    parameter int CNT_W  = CNT_W_DEF,
    parameter int HI_W   = HI_W_DEF,
    parameter int DEAD_W = DEAD_W_DEF
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [CNT_W-1:0]      tb_count,
    input  logic                  tb_wrap,
    input  logic [HI_W-1:0]       duty_hi,
    input  logic [CNT_W-HI_W-1:0] duty_lo,
    input  logic [1:0]            out_cfg,
    input  logic [3:0]            mode,
    input  logic [DEAD_W-1:0]     dead_dly,
    output logic [NPIN-1:0]       pin_lvl,
    output logic [NPIN-1:0]       pin_en
);
    localparam int NCH = 2;

    logic             clr;
    logic             half;
    logic             pwm_raw;
    logic [CNT_W-1:0] duty_shadow;
    logic [NCH-1:0]   ch_in;
    logic [NCH-1:0]   ch_out;
    logic [DEAD_W-1:0] ch_dly [NCH];
    logic             mod_a;
    logic             mod_b;

    assign clr  = mode_is_off(mode);
    assign half = (steer_cfg_e'(out_cfg) == CFG_HALF);

    epwm_duty_cmp #(.CNT_W(CNT_W), .HI_W(HI_W)) duty_i (
        .clk      (clk),
        .rst      (rst),
        .clr      (clr),
        .wrap     (tb_wrap),
        .cnt      (tb_count),
        .duty_hi  (duty_hi),
        .duty_lo  (duty_lo),
        .pwm_o    (pwm_raw),
        .shadow_o (duty_shadow)
    );

    assign ch_in[0]  = pwm_raw;
    assign ch_in[1]  = half & ~pwm_raw;
    assign ch_dly[0] = half ? dead_dly : '0;
    assign ch_dly[1] = dead_dly;

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        epwm_deadband #(.DEAD_W(DEAD_W)) db_i (
            .clk   (clk),
            .rst   (rst),
            .clr   (clr),
            .in_i  (ch_in[g]),
            .dly_i (ch_dly[g]),
            .out_o (ch_out[g])
        );
    end

    assign mod_a = ch_out[0];
    assign mod_b = ch_out[1];

    epwm_route route_i (
        .mode    (mode),
        .out_cfg (out_cfg),
        .mod_a   (mod_a),
        .mod_b   (mod_b),
        .pin_lvl (pin_lvl),
        .pin_en  (pin_en)
    );
endmodule

// File: rtl/epwm_steer_chk.sv
module epwm_steer_chk
    import epwm_steer_pkg::*;
#(
    parameter int CNT_W = CNT_W_DEF,
    parameter int HI_W  = HI_W_DEF
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  tb_wrap,
    input logic [HI_W-1:0]       duty_hi,
    input logic [CNT_W-HI_W-1:0] duty_lo,
    input logic [1:0]            out_cfg,
    input logic [3:0]            mode,
    input logic                  pwm_raw,
    input logic [CNT_W-1:0]      shadow,
    input logic                  mod_a,
    input logic                  mod_b,
    input logic [NPIN-1:0]       pin_lvl,
    input logic [NPIN-1:0]       pin_en
);
    assert_pair_exclusive_R11: assert property (@(posedge clk) disable iff (rst)
        (mode_is_pwm(mode) && out_cfg == CFG_HALF) |-> !(mod_a && mod_b));

    assert_shadow_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (!tb_wrap && !mode_is_off(mode)) |=> $stable(shadow));

    assert_off_clear_R10: assert property (@(posedge clk) disable iff (rst)
        mode_is_off(mode) |=> (shadow == '0 && !pwm_raw && !mod_a && !mod_b));

    assert_zero_duty_R2: assert property (@(posedge clk) disable iff (rst)
        (tb_wrap && {duty_hi, duty_lo} == '0 && !mode_is_off(mode)) |=> !pwm_raw);

    assert_rise_after_input_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(mod_a) |-> $past(pwm_raw));

    assert_released_R9: assert property (@(posedge clk) disable iff (rst)
        !mode_is_pwm(mode) |-> (pin_en == '0 && pin_lvl == '0));
endmodule

bind epwm_steer epwm_steer_chk #(.CNT_W(CNT_W), .HI_W(HI_W)) chk_i (
    .clk     (clk),
    .rst     (rst),
    .tb_wrap (tb_wrap),
    .duty_hi (duty_hi),
    .duty_lo (duty_lo),
    .out_cfg (out_cfg),
    .mode    (mode),
    .pwm_raw (pwm_raw),
    .shadow  (duty_shadow),
    .mod_a   (mod_a),
    .mod_b   (mod_b),
    .pin_lvl (pin_lvl),
    .pin_en  (pin_en)
);

// File: tb/epwm_steer_tb.sv
module epwm_steer_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int PER        = 40;

    logic       clk = 1'b0;
    logic       rst;
    logic [9:0] tb_count;
    logic       tb_wrap;
    logic [7:0] duty_hi;
    logic [1:0] duty_lo;
    logic [1:0] out_cfg;
    logic [3:0] mode;
    logic [5:0] dead_dly;
    logic [3:0] pin_lvl;
    logic [3:0] pin_en;

    int          c_ctr = 0;
    int          dcur  = 0;
    logic [63:0] ha = '0;
    logic [63:0] hb = '0;
    bit          chk_on = 1'b0;
    string       tag = "";
    int          nvec = 0;
    int          nfail = 0;
    bit          done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    epwm_steer dut_i (
        .clk(clk), .rst(rst), .tb_count(tb_count), .tb_wrap(tb_wrap),
        .duty_hi(duty_hi), .duty_lo(duty_lo), .out_cfg(out_cfg),
        .mode(mode), .dead_dly(dead_dly), .pin_lvl(pin_lvl), .pin_en(pin_en)
    );

    task automatic report(input string t, input logic [3:0] en_e, input logic [3:0] lvl_e);
        nvec++;
        if (pin_en !== en_e || pin_lvl !== lvl_e) begin
            nfail++;
            $display("FAIL %s: en=%b lvl=%b expected en=%b lvl=%b", t, pin_en, pin_lvl, en_e, lvl_e);
        end
    endtask

    task automatic compare();
        logic [3:0] act, en, lvl;
        logic am, bm;
        int da;
        da = (out_cfg == 2'b10) ? int'(dead_dly) : 0;
        am = 1'b1;
        bm = 1'b1;
        for (int i = 1; i <= da + 1; i++) am &= ha[i];
        for (int i = 1; i <= int'(dead_dly) + 1; i++) bm &= hb[i];
        case (out_cfg)
            2'b00: begin act = {3'b000, am};          en = 4'b0001; end
            2'b01: begin act = {am, 2'b00, 1'b1};     en = 4'b1111; end
            2'b10: begin act = {2'b00, bm, am};       en = 4'b0011; end
            default: begin act = {1'b0, 1'b1, am, 1'b0}; en = 4'b1111; end
        endcase
        if (mode[3:2] != 2'b11) begin act = '0; en = '0; end
        lvl = en & (act ^ {mode[0], mode[1], mode[0], mode[1]});
        report(tag, en, lvl);
        if (mode[3:2] == 2'b11 && out_cfg == 2'b10) begin
            nvec++;
            if ((pin_lvl[0] ^ mode[1]) && (pin_lvl[1] ^ mode[0])) begin
                nfail++;
                $display("FAIL R11: lvl=%b expected A and B not both active", pin_lvl);
            end
        end
    endtask

    task automatic step();
        logic raw;
        @(negedge clk);
        if (chk_on) compare();
        tb_count = 10'(c_ctr);
        tb_wrap  = (c_ctr == 0);
        if (mode == 4'b0000) dcur = 0;
        else if (c_ctr == 0) dcur = int'(duty_hi) * 4 + int'(duty_lo);
        raw = (c_ctr < dcur);
        ha = {ha[62:0], (mode == 4'b0000) ? 1'b0 : raw};
        hb = {hb[62:0], (mode == 4'b0000 || out_cfg != 2'b10) ? 1'b0 : ~raw};
        c_ctr = (c_ctr == PER - 1) ? 0 : c_ctr + 1;
    endtask

    task automatic run(input string t, input int settle, input int n);
        chk_on = 1'b0;
        repeat (settle) step();
        tag = t;
        chk_on = 1'b1;
        repeat (n) step();
        chk_on = 1'b0;
    endtask

    task automatic set_duty(input int d);
        duty_hi = 8'(d / 4);
        duty_lo = 2'(d % 4);
    endtask

    task automatic t_reset();
        rst = 1'b1; mode = 4'b1110; out_cfg = 2'b00; dead_dly = '0; set_duty(0);
        repeat (4) step();
        @(negedge clk);
        report("R12 reset idle level", 4'b0001, 4'b0001);
        rst = 1'b0;
    endtask

    task automatic t_single();
        out_cfg = 2'b00; mode = 4'b1100;
        set_duty(23); run("R1 R4 single duty 23", 2*PER, 2*PER);
        set_duty(6);  run("R1 R4 single duty 6", 2*PER, 2*PER);
        set_duty(1);  run("R1 single duty 1", 2*PER, 2*PER);
    endtask

    task automatic t_edges();
        out_cfg = 2'b00; mode = 4'b1100;
        set_duty(0);    run("R2 zero duty", 2*PER, 2*PER);
        set_duty(1023); run("R2 full duty", 2*PER, 2*PER);
        set_duty(PER);  run("R2 duty equals period", 2*PER, 2*PER);
    endtask

    task automatic t_shadow();
        out_cfg = 2'b00; mode = 4'b1100;
        set_duty(10); run("R3 before rewrite", 2*PER, 4);
        tag = "R3 mid-period rewrite"; chk_on = 1'b1;
        while (c_ctr != 15) step();
        set_duty(30);
        repeat (2*PER) step();
        while (c_ctr != PER - 1) step();
        set_duty(5);
        repeat (2*PER) step();
        chk_on = 1'b0;
    endtask

    task automatic t_bridges();
        mode = 4'b1100; set_duty(17);
        out_cfg = 2'b01; run("R5 forward bridge", 2*PER, 2*PER);
        out_cfg = 2'b11; run("R7 reverse bridge", 2*PER, 2*PER);
    endtask

    task automatic t_half();
        out_cfg = 2'b10; mode = 4'b1100;
        set_duty(20); dead_dly = 6'd3; run("R6 R11 half dead 3", 2*PER + 8, 2*PER);
        dead_dly = 6'd0;  run("R6 half dead 0", 2*PER + 8, 2*PER);
        set_duty(9); dead_dly = 6'd7; run("R6 R11 half dead 7", 2*PER + 8, 2*PER);
        set_duty(0); dead_dly = 6'd2; run("R6 half zero duty", 2*PER + 8, 2*PER);
        dead_dly = 6'd0;
    endtask

    task automatic t_polarity();
        set_duty(14);
        out_cfg = 2'b01;
        for (int m = 12; m <= 15; m++) begin
            mode = 4'(m);
            run("R8 polarity forward", 2, PER);
        end
        out_cfg = 2'b11;
        for (int m = 12; m <= 15; m++) begin
            mode = 4'(m);
            run("R8 polarity reverse", 2, PER);
        end
        out_cfg = 2'b10; dead_dly = 6'd2; mode = 4'b1111;
        run("R8 polarity half active-low", 2*PER + 8, 2*PER);
        dead_dly = 6'd0;
    endtask

    task automatic t_nonpwm();
        set_duty(14); out_cfg = 2'b01;
        mode = 4'b0010; run("R9 mode 0010 released", 1, PER);
        mode = 4'b0111; run("R9 mode 0111 released", 1, PER);
        mode = 4'b1010; run("R9 mode 1010 released", 1, PER);
        out_cfg = 2'b10;
        mode = 4'b1011; run("R9 mode 1011 released", 1, PER);
    endtask

    task automatic t_off();
        out_cfg = 2'b00; mode = 4'b1100; set_duty(15);
        run("R10 before clear", 2*PER, 2);
        tag = "R10 clear and re-enable"; chk_on = 1'b1;
        while (c_ctr != 5) step();
        mode = 4'b0000;
        repeat (3) step();
        mode = 4'b1100;
        repeat (2*PER) step();
        chk_on = 1'b0;
    endtask

    initial begin
        tb_count = '0; tb_wrap = 1'b0; rst = 1'b1;
        t_reset();
        t_single();
        t_edges();
        t_shadow();
        t_bridges();
        t_half();
        t_polarity();
        t_nonpwm();
        t_off();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            done = 1'b1;
            nfail++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
            $finish;
        end
    end
endmodule